// File: doc/BRIEF.md
# Software Write-Protection Command Sequencer

This block sits beside the write path of a parallel byte memory and watches every write strobe. It looks for fixed multi-write command sequences made of address/data pairs. A three-write sequence turns software protection on. The same three writes, issued while protection is on, unlock the writes that follow. A six-write sequence turns protection off. The writes that form a command are swallowed: they are never committed and they start no busy timer.

When protection is off, every write that is not a command step is committed. When protection is on, a data write is committed only in a short unlocked window. That window opens when the three-write sequence completes. It stays open while further data writes follow one another within the window timeout, so a page of bytes can go through. A locked write still raises the busy-timer start, so the external write timer runs and reads during that time act as status polls. The write commits nothing.

The protection bit is held as nonvolatile state. It is cleared only by the asynchronous reset, which models first power-up with protection off, and by the disable sequence. A modelled power cycle input leaves the bit alone. It clears the partial sequence, the unlock and the timeout state.

Top module: `wprot_sequencer`

## Requirements
- R1: After reset, prot_o, commit_o and tstart_o are all 0.
- R2: With protection off, a write that is not a command step drives commit_o and tstart_o high for exactly the one cycle after the clock edge that samples the strobe.
- R3: The writes 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0xA0 (address/data), each within the window of the one before, set prot_o from the edge that samples the third write. None of the three writes raises commit_o or tstart_o.
- R4: With protection on and no unlock open, a data write raises tstart_o and leaves commit_o low.
- R5: After the enable sequence, the next data write commits. Each later data write within WIN_CYCLES cycles of the previous write also commits. A write more than WIN_CYCLES cycles after the previous write is locked again.
- R6: The six writes 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0x80, 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0x20 clear prot_o from the edge that samples the sixth write. All six are swallowed, and data writes commit again afterwards.
- R7: A write that does not match the next expected step returns the matcher to idle. That write is handled as a data write, and the rest of the broken sequence unlocks nothing.
- R8: Two sequence steps whose strobes are WIN_CYCLES cycles apart still chain. At WIN_CYCLES+1 cycles apart the partial sequence is dropped.
- R9: A pulse on pwr_cycle_i leaves prot_o unchanged. It discards any partial sequence and any open unlock.
- R10: The command addresses hold ordinary data: a write to 0x1555 with data that is not the next step commits whenever a data write would.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; first power-up, protection off |
| pwr_cycle_i | input | 1 | Modelled power cycle; clears volatile state, keeps protection |
| wr_stb_i | input | 1 | One-cycle pulse per write event |
| addr_i | input | AW | Write address |
| data_i | input | DW | Write data |
| commit_o | output | 1 | Write may be stored; pulse one cycle after the strobe |
| tstart_o | output | 1 | Busy write timer start; pulse one cycle after the strobe |
| prot_o | output | 1 | Software protection state |

## Verification
A matcher index that is wrong or stuck shows up within one write. A completing step that fails to complete leaves prot_o unchanged. A spurious hit swallows a data write, so both commit_o and tstart_o stay low where a pulse is due. A timeout counter that is off by one appears only at the window boundary, so steps and page writes are placed exactly WIN_CYCLES and WIN_CYCLES+1 cycles apart. An unlock flag that is lost or that outlives the window is seen on the next protected write, as commit_o differing from the expected value while tstart_o still pulses.

// File: rtl/wps_pkg.sv
package wps_pkg;
  typedef enum logic [1:0] {
    K_IDLE,
    K_STEP,
    K_DATA_OK,
    K_DATA_LOCKED
  } wr_kind_e;
endpackage

// File: rtl/wps_window.sv
module wps_window #(
  parameter int WIN_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic stb_i,
  output logic expired_o
);
  localparam int CW = $clog2(WIN_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  // cycles since the last write, saturating at the limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= CW'(WIN_CYCLES);
    else if (clr_i)                   cnt_q <= CW'(WIN_CYCLES);
    else if (stb_i)                   cnt_q <= '0;
    else if (cnt_q != CW'(WIN_CYCLES)) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == CW'(WIN_CYCLES));

  p_cnt_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(WIN_CYCLES));
  p_stb_reopens_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !clr_i) |=> !expired_o);
endmodule

// File: rtl/wps_matcher.sv
module wps_matcher #(
  parameter int AW = 13,
  parameter int DW = 8,
  parameter int N_STEPS = 3,
  parameter logic [N_STEPS*AW-1:0] ADDRS = '0,
  parameter logic [N_STEPS*DW-1:0] DATAS = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          stale_i,
  input  logic          stb_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          hit_o,
  output logic          done_o
);
  localparam int IW = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;
  localparam int NT = 2 ** IW;

  logic [AW-1:0] step_addr [NT];
  logic [DW-1:0] step_data [NT];
  logic [NT-1:0] step_valid;

  for (genvar i = 0; i < NT; i++) begin : g_step
    if (i < N_STEPS) begin : g_used
      assign step_addr[i]  = ADDRS[i*AW +: AW];
      assign step_data[i]  = DATAS[i*DW +: DW];
      assign step_valid[i] = 1'b1;
    end else begin : g_pad
      assign step_addr[i]  = '0;
      assign step_data[i]  = '0;
      assign step_valid[i] = 1'b0;
    end
  end

  logic [IW-1:0] idx_q, cur;
  assign cur    = stale_i ? '0 : idx_q;
  assign hit_o  = stb_i && step_valid[cur] &&
                  (addr_i == step_addr[cur]) && (data_i == step_data[cur]);
  assign done_o = hit_o && (cur == IW'(N_STEPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (clr_i)   idx_q <= '0;
    else if (stb_i)   idx_q <= (hit_o && !done_o) ? cur + 1'b1 : '0;
    else if (stale_i) idx_q <= '0;
  end

  p_idx_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < IW'(N_STEPS));
  p_miss_idles_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !hit_o) |=> idx_q == '0);
endmodule

// File: rtl/wprot_sequencer.sv
module wprot_sequencer
  import wps_pkg::*;
#(
  parameter int AW = 13,
  parameter int DW = 8,
  parameter int WIN_CYCLES = 64,
  parameter int EN_STEPS = 3,
  parameter int DIS_STEPS = 6,
  parameter logic [EN_STEPS*AW-1:0]  EN_ADDRS  = {13'h1555, 13'h0AAA, 13'h1555},
  parameter logic [EN_STEPS*DW-1:0]  EN_DATAS  = {8'hA0, 8'h55, 8'hAA},
  parameter logic [DIS_STEPS*AW-1:0] DIS_ADDRS = {13'h1555, 13'h0AAA, 13'h1555,
                                                  13'h1555, 13'h0AAA, 13'h1555},
  parameter logic [DIS_STEPS*DW-1:0] DIS_DATAS = {8'h20, 8'h55, 8'hAA,
                                                  8'h80, 8'h55, 8'hAA}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_cycle_i,
  input  logic          wr_stb_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          commit_o,
  output logic          tstart_o,
  output logic          prot_o
);
  logic prot_q, armed_q, commit_q, tstart_q;
  logic expired, armed_eff, wr_ok, seq_stb;
  logic en_hit, en_done, dis_hit, dis_done, is_cmd;
  wr_kind_e kind;

  assign wr_ok     = wr_stb_i && !pwr_cycle_i;
  assign armed_eff = armed_q && !expired;
  // an open unlock turns every write into data
  assign seq_stb   = wr_ok && !armed_eff;

  wps_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk_i, .rst_ni, .clr_i(pwr_cycle_i), .stb_i(wr_ok), .expired_o(expired)
  );

  wps_matcher #(.AW(AW), .DW(DW), .N_STEPS(EN_STEPS),
                .ADDRS(EN_ADDRS), .DATAS(EN_DATAS)) u_en (
    .clk_i, .rst_ni, .clr_i(pwr_cycle_i), .stale_i(expired), .stb_i(seq_stb),
    .addr_i, .data_i, .hit_o(en_hit), .done_o(en_done)
  );

  wps_matcher #(.AW(AW), .DW(DW), .N_STEPS(DIS_STEPS),
                .ADDRS(DIS_ADDRS), .DATAS(DIS_DATAS)) u_dis (
    .clk_i, .rst_ni, .clr_i(pwr_cycle_i), .stale_i(expired), .stb_i(seq_stb),
    .addr_i, .data_i, .hit_o(dis_hit), .done_o(dis_done)
  );

  assign is_cmd = en_hit || dis_hit;

  always_comb begin
    if (!wr_ok)                       kind = K_IDLE;
    else if (is_cmd)                  kind = K_STEP;
    else if (!prot_q || armed_eff)    kind = K_DATA_OK;
    else                              kind = K_DATA_LOCKED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q   <= 1'b0;
      armed_q  <= 1'b0;
      commit_q <= 1'b0;
      tstart_q <= 1'b0;
    end else begin
      commit_q <= (kind == K_DATA_OK);
      tstart_q <= (kind == K_DATA_OK) || (kind == K_DATA_LOCKED);
      if (pwr_cycle_i) begin
        armed_q <= 1'b0;
      end else if (en_done) begin
        prot_q  <= 1'b1;
        armed_q <= 1'b1;
      end else if (dis_done) begin
        prot_q  <= 1'b0;
        armed_q <= 1'b0;
      end else if (wr_ok) begin
        armed_q <= armed_eff;
      end else if (expired) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign commit_o = commit_q;
  assign tstart_o = tstart_q;
  assign prot_o   = prot_q;

  p_commit_timer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> tstart_o);
  p_cmd_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cmd |=> (!tstart_o && !commit_o));
  p_rise_arms_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prot_o) |-> armed_q);
  p_pwr_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_cycle_i |=> (prot_o == $past(prot_o)) && !armed_q);
endmodule

// File: tb/sim_wprot_sequencer.sv
`timescale 1ns/1ps
module sim_wprot_sequencer;
  localparam int AW = 13;
  localparam int DW = 8;
  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr = 1'b0;
  logic stb = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic commit, tstart, prot;

  int n_chk = 0;
  int n_fail = 0;
  logic strobe_d = 1'b0;
  logic [2:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  wprot_sequencer #(.AW(AW), .DW(DW), .WIN_CYCLES(WIN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_cycle_i(pwr), .wr_stb_i(stb),
    .addr_i(addr), .data_i(data),
    .commit_o(commit), .tstart_o(tstart), .prot_o(prot)
  );

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {commit,tstart,prot} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  always @(posedge clk) strobe_d <= stb && !pwr;

  // monitor: pops one expected item per sampled write
  always @(negedge clk) begin
    if (rst_n) begin
      if (strobe_d) begin
        if (exp_q.size() == 0) begin
          check("QUEUE", 3'b111, 3'b000);
        end else begin
          logic [2:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {commit, tstart, prot}, e);
        end
      end else begin
        check("IDLE", {commit, tstart, 1'b0}, 3'b000);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic c, input logic t, input logic p, input string tag);
    exp_q.push_back({c, t, p});
    tag_q.push_back(tag);
    addr = a;
    data = d;
    stb  = 1'b1;
    @(negedge clk);
    stb  = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pwr_pulse(input logic p, input string tag);
    pwr = 1'b1;
    @(negedge clk);
    pwr = 1'b0;
    check(tag, {1'b0, 1'b0, prot}, {2'b00, p});
  endtask

  task automatic enable_seq(input logic p0, input string tag);
    wr(13'h1555, 8'hAA, 0, 0, p0, tag);
    wr(13'h0AAA, 8'h55, 0, 0, p0, tag);
    wr(13'h1555, 8'hA0, 0, 0, 1, tag);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    idle(2);
    check("R1 reset", {commit, tstart, prot}, 3'b000);
    rst_n = 1'b1;
    idle(1);
    check("R1 after release", {commit, tstart, prot}, 3'b000);

    wr(13'h0100, 8'h11, 1, 1, 0, "R2 plain write");
    wr(13'h1FFF, 8'h22, 1, 1, 0, "R2 plain write top addr");
    wr(13'h1555, 8'h33, 1, 1, 0, "R10 cmd addr user data, off");
    idle(3);

    enable_seq(0, "R3 enable");
    wr(13'h0200, 8'h44, 1, 1, 1, "R5 first unlocked write");
    wr(13'h0201, 8'h45, 1, 1, 1, "R5 page write");
    idle(WIN - 1);
    wr(13'h0202, 8'h46, 1, 1, 1, "R5 page write at window edge");
    idle(WIN);
    wr(13'h0203, 8'h47, 0, 1, 1, "R5 window closed");
    wr(13'h0300, 8'h66, 0, 1, 1, "R4 locked write");

    idle(WIN + 1);
    enable_seq(1, "R3 enable while on");
    wr(13'h1555, 8'h77, 1, 1, 1, "R10 cmd addr user data, unlocked");

    idle(WIN + 1);
    wr(13'h1555, 8'hAA, 0, 0, 1, "R7 step1");
    wr(13'h0AAA, 8'h55, 0, 0, 1, "R7 step2");
    wr(13'h0400, 8'h99, 0, 1, 1, "R7 breaking write locked");
    wr(13'h1555, 8'hA0, 0, 1, 1, "R7 late third step is data");
    wr(13'h0401, 8'h9A, 0, 1, 1, "R7 no unlock");

    idle(WIN + 1);
    wr(13'h1555, 8'hAA, 0, 0, 1, "R8 step gap");
    idle(WIN - 1);
    wr(13'h0AAA, 8'h55, 0, 0, 1, "R8 step at window edge");
    idle(WIN - 1);
    wr(13'h1555, 8'hA0, 0, 0, 1, "R8 step at window edge");
    wr(13'h0500, 8'hB0, 1, 1, 1, "R8 chained sequence unlocks");
    idle(WIN + 1);
    wr(13'h1555, 8'hAA, 0, 0, 1, "R8 step1");
    idle(WIN);
    wr(13'h0AAA, 8'h55, 0, 1, 1, "R8 timed out step is data");
    wr(13'h1555, 8'hA0, 0, 1, 1, "R8 no completion");

    idle(WIN + 1);
    wr(13'h1555, 8'hAA, 0, 0, 1, "R9 step1");
    wr(13'h0AAA, 8'h55, 0, 0, 1, "R9 step2");
    pwr_pulse(1, "R9 prot kept");
    wr(13'h1555, 8'hA0, 0, 1, 1, "R9 partial sequence dropped");
    idle(WIN + 1);
    enable_seq(1, "R9 enable");
    pwr_pulse(1, "R9 prot kept");
    wr(13'h0700, 8'hC0, 0, 1, 1, "R9 unlock dropped");

    idle(WIN + 1);
    wr(13'h1555, 8'hAA, 0, 0, 1, "R6 disable");
    wr(13'h0AAA, 8'h55, 0, 0, 1, "R6 disable");
    wr(13'h1555, 8'h80, 0, 0, 1, "R6 disable");
    wr(13'h1555, 8'hAA, 0, 0, 1, "R6 disable");
    wr(13'h0AAA, 8'h55, 0, 0, 1, "R6 disable");
    wr(13'h1555, 8'h20, 0, 0, 0, "R6 disable done");
    wr(13'h0600, 8'hD0, 1, 1, 0, "R6 writes commit again");
    pwr_pulse(0, "R9 off kept");
    wr(13'h0601, 8'hD1, 1, 1, 0, "R2 after power cycle");

    idle(2);
    check("queue drained", {1'b0, 2'(exp_q.size())}, 3'b000);
    report();
    $finish;
  end
endmodule